// File: doc/BRIEF.md
# Sequential Binary-to-BCD Converter

This block turns an unsigned binary word of parameterised width `BIN_W` into packed decimal digits. It uses the shift-and-add-3 method and does one correction-and-shift step per clock. The caller pulses `start` with the value on `bin_in` while the block is idle. `busy` then stays high for the whole conversion. A one-cycle `done` pulse marks the moment `bcd_out` holds the new result.

The working register joins a digit field and a binary field. Before each left shift, every full decimal column holding 5 or more gets 3 added to it. No column can reach 5 during the first three shifts, so the input is loaded as if three shifts had already happened. That leaves `BIN_W-3` steps. The digit count and the width of the top digit come from the largest input value. With 8 bits the output is 10 bits wide: a 2-bit hundreds digit over tens and units. With 16 bits it is 19 bits wide. The top column can never reach 5 before a shift, so it gets no correction logic.

The control is a three-state machine:
- `ST_IDLE` waits for `start`; start taken moves it to `ST_STEP`.
- `ST_STEP` runs one correction-and-shift per cycle. It stays there while steps remain and moves to `ST_FINISH` after the last step.
- `ST_FINISH` registers the result and `done` on its way back to `ST_IDLE`; this transition is unconditional.

Top module: `bcd_seq_conv`

## Requirements
- R1: Before each left shift, each corrected decimal column whose value is 5 to 9 becomes that value plus 3. A column holding 0 to 4 passes unchanged.
- R2: After a conversion, `bcd_out` equals the decimal value of the captured input. Digit i (units = 0) sits at bits 4i+3..4i, and every digit below the top one is in the range 0 to 9.
- R3: With `BIN_W` = 8 the output is 10 bits, with a 2-bit top (hundreds) digit. Input 0xFF gives digits 2,5,5 and input 0x3F gives 0,6,3.
- R4: `done` rises exactly `BIN_W-2` rising edges after the edge that captures `start`, for every input value including zero.
- R5: A `start` high in idle captures `bin_in`, and `busy` is high from the next cycle. A `start` while `busy` is high is ignored and produces no extra result.
- R6: `done` is high for one cycle only per conversion, and `busy` is low in that cycle.
- R7: `bcd_out` keeps its value in every cycle in which `done` is low.
- R8: Synchronous reset forces `busy`, `done` and `bcd_out` to zero and abandons any conversion in progress.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| start | input | 1 | Begin a conversion of `bin_in` (taken only when idle) |
| bin_in | input | BIN_W | Unsigned binary value |
| busy | output | 1 | Conversion in progress |
| done | output | 1 | One-cycle pulse: `bcd_out` just updated |
| bcd_out | output | OUT_W | Packed decimal digits, units lowest, top digit trimmed |

## Verification
The assertions assume `start` is only meaningful while idle and that reset is held long enough for one clock edge. The latency and hold properties also assume `bin_in` is captured on a single edge, so its later changes have no effect. The stimulus waits for `busy` to fall before each real start. It deliberately pulses `start` during a busy window to exercise the ignore rule. It changes `bin_in` freely while a conversion runs, because the block must not depend on it then. Reset is applied once at the start and once in the middle of a conversion, and the scoreboard is flushed at that point.

// File: rtl/bcd_conv_pkg.sv
package bcd_conv_pkg;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_STEP,
        ST_FINISH
    } conv_state_e;

    // Number of decimal digits needed for 2**w - 1.
    function automatic int dec_digits(input int w);
        longint unsigned m;
        int n;
        m = (longint'(1) << w) - 1;
        n = 0;
        while (m > 0) begin
            m = m / 10;
            n = n + 1;
        end
        if (n == 0) n = 1;
        return n;
    endfunction

    // Largest value the most significant digit can take.
    function automatic int top_digit_max(input int w);
        longint unsigned m;
        int n;
        m = (longint'(1) << w) - 1;
        n = dec_digits(w);
        for (int i = 0; i < n - 1; i++) m = m / 10;
        return int'(m);
    endfunction

    function automatic int top_digit_width(input int w);
        return $clog2(top_digit_max(w) + 1);
    endfunction

    function automatic int out_width(input int w);
        return 4 * (dec_digits(w) - 1) + top_digit_width(w);
    endfunction

endpackage

// File: rtl/bcd_digit_adj.sv
module bcd_digit_adj (
    input  logic [3:0] d_in,
    output logic [3:0] d_out
);
    always_comb begin
        if (d_in >= 4'd5) d_out = d_in + 4'd3;
        else              d_out = d_in;
    end
endmodule

// File: rtl/bcd_adj_array.sv
module bcd_adj_array #(
    parameter int WORK_W = 15,
    parameter int NDIG   = 3,
    parameter int TOP_W  = 2,
    parameter int BOFF   = 5
) (
    input  logic [WORK_W-1:0] z_in,
    output logic [WORK_W-1:0] z_out
);
    // Binary part below the digit field is passed straight through.
    generate
        if (BOFF > 0) begin : g_bin
            assign z_out[BOFF-1:0] = z_in[BOFF-1:0];
        end
        for (genvar g = 0; g < NDIG - 1; g++) begin : g_dig
            bcd_digit_adj u_adj (
                .d_in  (z_in [BOFF + 4*g +: 4]),
                .d_out (z_out[BOFF + 4*g +: 4])
            );
        end
        // The top column never reaches 5 before a shift: no correction.
        assign z_out[WORK_W-1 -: TOP_W] = z_in[WORK_W-1 -: TOP_W];
    endgenerate
endmodule

// File: rtl/bcd_step_ctr.sv
module bcd_step_ctr #(
    parameter int STEPS = 5,
    localparam int CW   = $clog2(STEPS) + 1
) (
    input  logic clk,
    input  logic rst,
    input  logic load,
    input  logic dec,
    output logic last
);
    logic [CW-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst)                 cnt_q <= '0;
        else if (load)           cnt_q <= CW'(STEPS - 1);
        else if (dec && cnt_q != '0) cnt_q <= cnt_q - 1'b1;
    end

    assign last = (cnt_q == '0);
endmodule

// File: rtl/bcd_seq_conv.sv
module bcd_seq_conv
    import bcd_conv_pkg::*;
#(
    parameter int  BIN_W = 8,
    localparam int OUT_W = out_width(BIN_W)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start,
    input  logic [BIN_W-1:0] bin_in,
    output logic             busy,
    output logic             done,
    output logic [OUT_W-1:0] bcd_out
);
    localparam int NDIG   = dec_digits(BIN_W);
    localparam int TOP_W  = top_digit_width(BIN_W);
    localparam int STEPS  = BIN_W - 3;
    localparam int BOFF   = BIN_W - 3;
    localparam int WORK_W = OUT_W + BOFF;

    conv_state_e state_q, state_d;
    logic [WORK_W-1:0] z_q, z_adj;
    logic [OUT_W-1:0]  bcd_q;
    logic              done_q;
    logic              take, step_last;

    assign take = (state_q == ST_IDLE) && start;

    // State register
    always_ff @(posedge clk) begin
        if (rst) state_q <= ST_IDLE;
        else     state_q <= state_d;
    end

    // Next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:   if (start)     state_d = ST_STEP;
            ST_STEP:   if (step_last) state_d = ST_FINISH;
            ST_FINISH:                state_d = ST_IDLE;
            default:                  state_d = ST_IDLE;
        endcase
    end

    bcd_step_ctr #(.STEPS(STEPS)) u_ctr (
        .clk  (clk),
        .rst  (rst),
        .load (take),
        .dec  (state_q == ST_STEP),
        .last (step_last)
    );

    bcd_adj_array #(
        .WORK_W (WORK_W),
        .NDIG   (NDIG),
        .TOP_W  (TOP_W),
        .BOFF   (BOFF)
    ) u_arr (
        .z_in  (z_q),
        .z_out (z_adj)
    );

    // Working register: loaded pre-shifted by three, then correct-and-shift.
    always_ff @(posedge clk) begin
        if (rst)                     z_q <= '0;
        else if (take)               z_q <= {{(WORK_W-BIN_W){1'b0}}, bin_in};
        else if (state_q == ST_STEP) z_q <= {z_adj[WORK_W-2:0], 1'b0};
    end

    // Output process
    always_ff @(posedge clk) begin
        if (rst) begin
            bcd_q  <= '0;
            done_q <= 1'b0;
        end else begin
            done_q <= (state_q == ST_FINISH);
            if (state_q == ST_FINISH) bcd_q <= z_q[WORK_W-1 -: OUT_W];
        end
    end

    assign busy    = (state_q != ST_IDLE);
    assign done    = done_q;
    assign bcd_out = bcd_q;
endmodule

// File: rtl/bcd_seq_conv_chk.sv
module bcd_seq_conv_chk
    import bcd_conv_pkg::*;
#(
    parameter int  BIN_W = 8,
    localparam int OUT_W = out_width(BIN_W)
) (
    input logic             clk,
    input logic             rst,
    input logic             start,
    input logic             busy,
    input logic             done,
    input logic [OUT_W-1:0] bcd_out
);
    localparam int NDIG  = dec_digits(BIN_W);
    localparam int STEPS = BIN_W - 3;
    localparam int LW    = $clog2(STEPS + 3) + 1;

    logic [LW-1:0] busy_cnt;

    always_ff @(posedge clk) begin
        if (rst)                 busy_cnt <= '0;
        else if (start && !busy) busy_cnt <= '0;
        else if (busy)           busy_cnt <= busy_cnt + 1'b1;
    end

    // R5: start taken in idle raises busy next cycle
    a_r5_busy_after_start: assert property (@(posedge clk) disable iff (rst)
        (start && !busy) |=> busy);

    // R6: done lasts one cycle
    a_r6_done_single: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    // R6: busy low while done is shown
    a_r6_done_not_busy: assert property (@(posedge clk) disable iff (rst)
        done |-> !busy);

    // R7: output stable without done
    a_r7_hold: assert property (@(posedge clk) disable iff (rst)
        !done |-> $stable(bcd_out));

    // R4: fixed latency, counted in busy cycles
    a_r4_latency: assert property (@(posedge clk) disable iff (rst)
        done |-> (busy_cnt == LW'(STEPS + 1)));

    // R8: reset clears outputs on the next cycle
    a_r8_reset_clear: assert property (@(posedge clk)
        rst |=> (!busy && !done && bcd_out == '0));

    // R2: lower digits are decimal when a result is shown
    generate
        for (genvar g = 0; g < NDIG - 1; g++) begin : g_dchk
            a_r2_digit_range: assert property (@(posedge clk) disable iff (rst)
                done |-> (bcd_out[4*g +: 4] <= 4'd9));
        end
    endgenerate
endmodule

bind bcd_seq_conv bcd_seq_conv_chk #(.BIN_W(BIN_W)) u_chk (
    .clk     (clk),
    .rst     (rst),
    .start   (start),
    .busy    (busy),
    .done    (done),
    .bcd_out (bcd_out)
);

// File: tb/bcd_seq_conv_bench.sv
module bcd_seq_conv_bench;
    import bcd_conv_pkg::*;

    localparam int BW    = 8;
    localparam int OW    = out_width(BW);
    localparam int NDIG  = dec_digits(BW);
    localparam int LAT   = (BW - 3) + 2;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          start = 1'b0;
    logic [BW-1:0] bin_in = '0;
    logic          busy, done;
    logic [OW-1:0] bcd_out;

    int checks = 0;
    int fails  = 0;
    int cyc    = 0;
    logic [OW-1:0] exp_q[$];
    int            t0_q[$];
    logic [OW-1:0] last_bcd = '0;
    logic          prev_done = 1'b0;
    bit            finished = 1'b0;

    always #4 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    bcd_seq_conv #(.BIN_W(BW)) u_bcd_seq_conv (
        .clk(clk), .rst(rst), .start(start), .bin_in(bin_in),
        .busy(busy), .done(done), .bcd_out(bcd_out)
    );

    function automatic logic [OW-1:0] ref_bcd(input int v);
        logic [4*NDIG-1:0] full;
        int x;
        full = '0;
        x = v;
        for (int i = 0; i < NDIG; i++) begin
            full[4*i +: 4] = 4'(x % 10);
            x = x / 10;
        end
        return full[OW-1:0];
    endfunction

    task automatic check(input bit ok, input string req,
                         input longint act, input longint expv);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h", req, act, expv);
        end
    endtask

    task automatic report();
        if (!finished) begin
            finished = 1'b1;
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    endtask

    // Driver: pushes the expected result and launch time.
    task automatic convert(input int v);
        @(negedge clk);
        while (busy) @(negedge clk);
        start  = 1'b1;
        bin_in = BW'(v);
        exp_q.push_back(ref_bcd(v));
        t0_q.push_back(cyc);
        @(negedge clk);
        start  = 1'b0;
        bin_in = ~BW'(v);          // R5: later input changes must not matter
        check(busy == 1'b1, "R5 busy after start", busy, 1);
    endtask

    task automatic drain();
        int n = 0;
        while ((exp_q.size() != 0 || busy) && n < 100) begin
            @(negedge clk);
            n++;
        end
        repeat (3) @(negedge clk);
        check(exp_q.size() == 0, "R4 all results delivered", exp_q.size(), 0);
    endtask

    // Monitor: pops and compares as results appear.
    always @(negedge clk) begin
        if (rst) begin
            last_bcd  <= bcd_out;
            prev_done <= 1'b0;
        end else begin
            if (done) begin
                check(!prev_done, "R6 done single cycle", prev_done, 0);
                check(!busy, "R6 busy low at done", busy, 0);
                if (exp_q.size() == 0) begin
                    check(1'b0, "R5 unexpected result", bcd_out, 0);
                end else begin
                    logic [OW-1:0] e;
                    int t;
                    e = exp_q.pop_front();
                    t = t0_q.pop_front();
                    check(bcd_out == e, "R2 R1 decimal value", bcd_out, e);
                    check(cyc - t == LAT, "R4 latency", cyc - t, LAT);
                end
            end else if (bcd_out != last_bcd) begin
                check(1'b0, "R7 output held", bcd_out, last_bcd);
            end
            last_bcd  <= bcd_out;
            prev_done <= done;
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        check(1'b0, "watchdog expired", cyc, 0);
        report();
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check(busy == 1'b0, "R8 busy after reset", busy, 0);
        check(done == 1'b0, "R8 done after reset", done, 0);
        check(bcd_out == '0, "R8 output after reset", bcd_out, 0);
        check($bits(bcd_out) == 10, "R3 output width", $bits(bcd_out), 10);

        convert(8'hFF);                       // R3: 2,5,5
        drain();
        check(bcd_out == 10'h255, "R3 0xFF digits", bcd_out, 10'h255);
        convert(8'h3F);                       // R3: 0,6,3
        drain();
        check(bcd_out == 10'h063, "R3 0x3F digits", bcd_out, 10'h063);
        convert(0);                           // R4: zero, no early exit
        drain();
        check(bcd_out == '0, "R4 zero input", bcd_out, 0);

        // R1 R2: every input value, back to back
        for (int v = 0; v < (1 << BW); v++) convert(v);
        drain();

        // R5: start while busy is ignored
        convert(200);
        @(negedge clk);
        start = 1'b1; bin_in = 8'd77;
        @(negedge clk);
        start = 1'b0;
        drain();
        check(bcd_out == 10'h200, "R5 busy start ignored", bcd_out, 10'h200);

        // R8: reset in the middle of a conversion
        convert(137);
        rst = 1'b1;
        exp_q.delete();
        t0_q.delete();
        repeat (2) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check(busy == 1'b0, "R8 busy after mid reset", busy, 0);
        check(bcd_out == '0, "R8 output after mid reset", bcd_out, 0);
        repeat (LAT + 2) @(negedge clk);
        check(done == 1'b0 && bcd_out == '0, "R8 conversion abandoned", bcd_out, 0);

        convert(99);
        drain();
        check(bcd_out == 10'h099, "R2 after reset recovery", bcd_out, 10'h099);
        report();
    end
endmodule